// File: doc/BRIEF.md
# Receive FIFO with Error Tagging

This block is the receive buffer of a UART-style serial port, placed between a local controller that produces received characters and a host that consumes them. Every entry holds a data byte and three error flags (parity, framing, break). The controller stages the flags for a character by loading a write-only shadow register. Its next data write stores the byte together with the staged flags in one entry. The shadow register then empties itself.

The host reads bytes from the head of the queue. It sees the flags of the head entry through a sticky status field, which collects errors across reads until the host reads its status. Two host interrupts report incoming data. One is a fill-level trigger, programmed through bits 7:6 of a host control byte. The other is a character time-out, raised when a partly filled queue sits unserviced for a programmed number of baud ticks. The time-out logic is a four-state machine:

- TM_IDLE: the queue is empty.
- TM_ARMED: the queue is below the trigger and the tick counter runs.
- TM_FIRED: the time-out is pending.
- TM_MET: the fill level is at or above the trigger.

Its transitions:

- *drain*: any state goes to TM_IDLE when the queue becomes empty.
- *reach*: any state goes to TM_MET when the fill level reaches the trigger.
- *arm*: TM_IDLE or TM_MET goes to TM_ARMED when the queue is non-empty and below the trigger. The counter is loaded.
- *restart*: TM_ARMED or TM_FIRED goes to TM_ARMED on an accepted controller write or host read. The counter is reloaded.
- *expire*: TM_ARMED goes to TM_FIRED on the baud tick that uses up the count.

The controller gets a flag when the host drains the queue empty.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty, fill_level is 0, host_rdata is 0, and host_err, host_ovr and all four interrupt outputs are 0.
- R2: Entries leave in the order they were written. An accepted host_rd presents the head byte on host_rdata in the cycle after the read. fill_level counts accepted writes minus accepted reads and never exceeds 16.
- R3: A ctl_wr while fill_level is 16 is dropped, even if a read occurs in the same cycle. It sets host_ovr. host_ovr clears on host_stat_rd, and a drop in the same cycle takes precedence over the clear.
- R4: A host_rd while the queue is empty leaves host_rdata and fill_level unchanged.
- R5: ctl_flag_we loads the shadow flags, with bit 0 parity, bit 1 framing and bit 2 break. The next accepted ctl_wr stores them with the byte and clears the shadow, so a later write without a new load stores 0 flags. A load in the same cycle as a write takes effect after that write.
- R6: The flags of an entry reach host_err only while that entry is at the head of the queue.
- R7: Each cycle, host_err ORs in the flags of the current head entry. It keeps bits from bytes already read. It goes to 0 for one cycle on host_stat_rd, and clearing wins over new flags in that cycle.
- R8: host_ctl_din[7:6], written with host_ctl_we, selects the trigger: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. The default is 00. host_rx_int is 1 exactly when fill_level is at or above the trigger.
- R9: While the queue is non-empty and below the trigger, host_tmo_int rises on the N-th baud_tick after the timer was armed or restarted, with no accepted write or read in between. N is the reload value written by ctl_tmo_we, default 4, and a value of 0 counts as 1. The reload value is captured when the timer is armed.
- R10: host_tmo_int clears when an accepted ctl_wr or host_rd restarts the timer, when the fill level reaches the trigger, or when the queue empties.
- R11: ctl_empty_int sets when an accepted read empties the queue, and this takes precedence over ctl_pend_rd. It clears when the queue becomes non-empty or on ctl_pend_rd.
- R12: host_ls_int is 1 exactly when host_lsi_en is 1 and the head entry of a non-empty queue carries any error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle baud tick that clocks the time-out counter |
| ctl_flag_we | input | 1 | Controller load of the shadow error flags |
| ctl_flag_din | input | 3 | Shadow flags: bit 0 parity, bit 1 framing, bit 2 break |
| ctl_wr | input | 1 | Controller data write |
| ctl_wdata | input | 8 | Controller data byte |
| ctl_tmo_we | input | 1 | Controller write of the time-out reload value |
| ctl_tmo_din | input | 8 | Time-out reload value in baud ticks |
| ctl_pend_rd | input | 1 | Controller read of its pending register, clears ctl_empty_int |
| host_rd | input | 1 | Host data read |
| host_rdata | output | 8 | Last byte read by the host |
| host_ctl_we | input | 1 | Host control byte write |
| host_ctl_din | input | 8 | Host control byte, bits 7:6 select the trigger |
| host_stat_rd | input | 1 | Host status read, clears host_err and host_ovr |
| host_lsi_en | input | 1 | Enable for the line-status interrupt |
| host_err | output | 3 | Sticky error status: parity, framing, break |
| host_ovr | output | 1 | Sticky overrun flag |
| host_rx_int | output | 1 | Fill-level trigger interrupt |
| host_tmo_int | output | 1 | Character time-out interrupt |
| host_ls_int | output | 1 | Line-status interrupt |
| ctl_empty_int | output | 1 | Controller interrupt: queue drained empty |
| fill_level | output | 5 | Number of stored entries |

## Verification
The hardest case to reach is the time-out interacting with its neighbours. A restart, a trigger change or a drain can land in the same cycle as an expiring baud tick. The reload value can change while the counter runs. A directed pass first sets up each of these cases on its own. It holds one byte under a trigger of four, ticks until the time-out expires, restarts it with a write, and fills up to the trigger. A long pseudo-random phase then mixes writes, reads, ticks, flag loads, trigger changes and reload writes at the same time. A behavioural queue model is compared with every output on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int FLAG_W = 3;

    // Bit 0 parity, bit 1 framing, bit 2 break.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } err_flags_t;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_ARMED,
        TM_FIRED,
        TM_MET
    } tmo_state_e;

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int EW   = DW + FLAG_W,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_entry,
    input  logic          rd_en,
    output logic [EW-1:0] head_entry,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] fill,
    output logic [CW-1:0] fill_nxt,
    output logic          wr_ok,
    output logic          rd_ok
);

    localparam logic [CW-1:0] FULL    = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_TOP = PW'(DEPTH - 1);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] fill_q;
    logic [DW-1:0] rdata_q;

    assign wr_ok = wr_en && (fill_q != FULL);
    assign rd_ok = rd_en && (fill_q != '0);

    always_comb begin
        fill_nxt = fill_q;
        unique case ({wr_ok, rd_ok})
            2'b10:   fill_nxt = fill_q + CW'(1);
            2'b01:   fill_nxt = fill_q - CW'(1);
            default: fill_nxt = fill_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr_q] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            fill_q  <= '0;
            rdata_q <= '0;
        end else begin
            fill_q <= fill_nxt;
            if (wr_ok) begin
                wptr_q <= (wptr_q == PTR_TOP) ? '0 : wptr_q + PW'(1);
            end
            if (rd_ok) begin
                rptr_q  <= (rptr_q == PTR_TOP) ? '0 : rptr_q + PW'(1);
                rdata_q <= mem[rptr_q][DW-1:0];
            end
        end
    end

    assign head_entry = (fill_q != '0) ? mem[rptr_q] : '0;
    assign rd_data    = rdata_q;
    assign fill       = fill_q;

endmodule

// File: rtl/rxf_status.sv
module rxf_status
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_din,
    input  logic              wr_en,
    input  logic              wr_ok,
    input  logic              rd_ok,
    input  logic              stat_rd,
    input  logic              pend_rd,
    input  logic [CW-1:0]     fill,
    input  logic [CW-1:0]     fill_nxt,
    input  logic [FLAG_W-1:0] head_flags,
    output logic [FLAG_W-1:0] shadow,
    output logic [FLAG_W-1:0] err,
    output logic              ovr,
    output logic              empty_int
);

    err_flags_t        shadow_q;
    logic [FLAG_W-1:0] err_q;
    logic              ovr_q;
    logic              empty_q;
    logic              drop;
    logic              drained;

    assign drop    = wr_en && !wr_ok;
    assign drained = rd_ok && (fill != '0) && (fill_nxt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            err_q    <= '0;
            ovr_q    <= 1'b0;
            empty_q  <= 1'b0;
        end else begin
            // Shadow: a new load wins over the post-copy clear.
            if (flag_we) begin
                shadow_q <= err_flags_t'(flag_din);
            end else if (wr_ok) begin
                shadow_q <= '0;
            end
            // Sticky error field.
            if (stat_rd) begin
                err_q <= '0;
            end else begin
                err_q <= err_q | head_flags;
            end
            // Overrun: a drop wins over the clear.
            ovr_q <= drop | (ovr_q & ~stat_rd);
            // Controller drain flag.
            if (fill_nxt != '0) begin
                empty_q <= 1'b0;
            end else if (drained) begin
                empty_q <= 1'b1;
            end else if (pend_rd) begin
                empty_q <= 1'b0;
            end
        end
    end

    assign shadow    = shadow_q;
    assign err       = err_q;
    assign ovr       = ovr_q;
    assign empty_int = empty_q;

endmodule

// File: rtl/rxf_tmo_fsm.sv
module rxf_tmo_fsm
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CW-1:0]    fill_nxt,
    input  logic [CW-1:0]    trig_nxt,
    input  logic [TMO_W-1:0] reload,
    output logic             tmo_int
);

    tmo_state_e       state_q, state_d;
    logic [TMO_W-1:0] timer_q;
    logic             load;
    logic             dec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        dec     = 1'b0;
        if (fill_nxt == '0) begin
            state_d = TM_IDLE;                    // drain
        end else if (fill_nxt >= trig_nxt) begin
            state_d = TM_MET;                     // reach
        end else begin
            unique case (state_q)
                TM_IDLE, TM_MET: begin            // arm
                    state_d = TM_ARMED;
                    load    = 1'b1;
                end
                TM_ARMED: begin
                    if (restart) begin            // restart
                        load = 1'b1;
                    end else if (tick) begin
                        if (timer_q <= TMO_W'(1)) begin
                            state_d = TM_FIRED;   // expire
                        end else begin
                            dec = 1'b1;
                        end
                    end
                end
                TM_FIRED: begin
                    if (restart) begin            // restart
                        state_d = TM_ARMED;
                        load    = 1'b1;
                    end
                end
                default: state_d = TM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (load) begin
            timer_q <= reload;
        end else if (dec) begin
            timer_q <= timer_q - TMO_W'(1);
        end
    end

    assign tmo_int = (state_q == TM_FIRED);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DW      = 8,
    parameter int TMO_W   = 8,
    parameter int TMO_RST = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              ctl_flag_we,
    input  logic [FLAG_W-1:0] ctl_flag_din,
    input  logic              ctl_wr,
    input  logic [DW-1:0]     ctl_wdata,
    input  logic              ctl_tmo_we,
    input  logic [TMO_W-1:0]  ctl_tmo_din,
    input  logic              ctl_pend_rd,
    input  logic              host_rd,
    output logic [DW-1:0]     host_rdata,
    input  logic              host_ctl_we,
    input  logic [7:0]        host_ctl_din,
    input  logic              host_stat_rd,
    input  logic              host_lsi_en,
    output logic [FLAG_W-1:0] host_err,
    output logic              host_ovr,
    output logic              host_rx_int,
    output logic              host_tmo_int,
    output logic              host_ls_int,
    output logic              ctl_empty_int,
    output logic [CW-1:0]     fill_level
);

    localparam int EW = DW + FLAG_W;
    localparam logic [CW-1:0] LVL_A = CW'(1);
    localparam logic [CW-1:0] LVL_B = CW'(DEPTH / 4);
    localparam logic [CW-1:0] LVL_C = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_D = CW'(DEPTH - 2);

    logic [EW-1:0]     head_entry;
    logic [CW-1:0]     fill, fill_nxt;
    logic              wr_ok, rd_ok;
    logic [FLAG_W-1:0] shadow;
    logic [FLAG_W-1:0] head_flags;
    logic [1:0]        trig_sel_q, trig_sel_d;
    logic [CW-1:0]     trig_lvl_q, trig_lvl_d;
    logic [TMO_W-1:0]  reload_q;

    function automatic logic [CW-1:0] lvl_of(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return LVL_A;
            2'b01:   return LVL_B;
            2'b10:   return LVL_C;
            default: return LVL_D;
        endcase
    endfunction

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr),
        .wr_entry   ({shadow, ctl_wdata}),
        .rd_en      (host_rd),
        .head_entry (head_entry),
        .rd_data    (host_rdata),
        .fill       (fill),
        .fill_nxt   (fill_nxt),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok)
    );

    assign head_flags = head_entry[EW-1:DW];

    rxf_status #(.DEPTH(DEPTH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_we    (ctl_flag_we),
        .flag_din   (ctl_flag_din),
        .wr_en      (ctl_wr),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .stat_rd    (host_stat_rd),
        .pend_rd    (ctl_pend_rd),
        .fill       (fill),
        .fill_nxt   (fill_nxt),
        .head_flags (head_flags),
        .shadow     (shadow),
        .err        (host_err),
        .ovr        (host_ovr),
        .empty_int  (ctl_empty_int)
    );

    assign trig_sel_d = host_ctl_we ? host_ctl_din[7:6] : trig_sel_q;
    assign trig_lvl_d = lvl_of(trig_sel_d);
    assign trig_lvl_q = lvl_of(trig_sel_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_sel_q <= 2'b00;
            reload_q   <= TMO_W'(TMO_RST);
        end else begin
            trig_sel_q <= trig_sel_d;
            if (ctl_tmo_we) begin
                reload_q <= ctl_tmo_din;
            end
        end
    end

    rxf_tmo_fsm #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .restart  (wr_ok | rd_ok),
        .fill_nxt (fill_nxt),
        .trig_nxt (trig_lvl_d),
        .reload   (reload_q),
        .tmo_int  (host_tmo_int)
    );

    assign host_rx_int = (fill >= trig_lvl_q);
    assign host_ls_int = host_lsi_en && (head_flags != '0);
    assign fill_level  = fill;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          host_rd,
    input logic          host_stat_rd,
    input logic          host_lsi_en,
    input logic [7:0]    host_rdata,
    input logic [2:0]    host_err,
    input logic          host_ovr,
    input logic          host_rx_int,
    input logic          host_tmo_int,
    input logic          host_ls_int,
    input logic          ctl_empty_int,
    input logic [CW-1:0] fill_level
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL);

    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FULL && ctl_wr && !host_rd) |=> (fill_level == FULL && host_ovr));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && host_rd && !ctl_wr) |=> ($stable(host_rdata) && fill_level == '0));

    assert_sticky_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_stat_rd |=> ((host_err & $past(host_err)) == $past(host_err)));

    assert_full_triggers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FULL) |-> host_rx_int);

    assert_tmo_below_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_tmo_int |-> (fill_level != '0 && !host_rx_int));

    assert_drain_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == ONE && host_rd && !ctl_wr) |=> ctl_empty_int);

    assert_nonempty_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level != '0) |-> !ctl_empty_int);

    assert_lsi_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_lsi_en || fill_level == '0) |-> !host_ls_int);

endmodule

bind rx_err_fifo rxf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr        (ctl_wr),
    .host_rd       (host_rd),
    .host_stat_rd  (host_stat_rd),
    .host_lsi_en   (host_lsi_en),
    .host_rdata    (host_rdata),
    .host_err      (host_err),
    .host_ovr      (host_ovr),
    .host_rx_int   (host_rx_int),
    .host_tmo_int  (host_tmo_int),
    .host_ls_int   (host_ls_int),
    .ctl_empty_int (ctl_empty_int),
    .fill_level    (fill_level)
);

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ctl_flag_we = 1'b0;
    logic [2:0] ctl_flag_din = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       ctl_tmo_we = 1'b0;
    logic [7:0] ctl_tmo_din = '0;
    logic       ctl_pend_rd = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_ctl_we = 1'b0;
    logic [7:0] host_ctl_din = '0;
    logic       host_stat_rd = 1'b0;
    logic       host_lsi_en = 1'b0;
    logic [7:0] host_rdata;
    logic [2:0] host_err;
    logic       host_ovr, host_rx_int, host_tmo_int, host_ls_int, ctl_empty_int;
    logic [4:0] fill_level;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Behavioural reference model.
    int q[$];
    int m_sh, m_err, m_ovr, m_dout, m_trig, m_rel, m_rel_arm, m_tcnt, m_cei;
    bit m_armed, m_texp;

    always #2.5 clk = ~clk;

    rx_err_fifo u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .ctl_flag_we(ctl_flag_we), .ctl_flag_din(ctl_flag_din),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_tmo_we(ctl_tmo_we), .ctl_tmo_din(ctl_tmo_din),
        .ctl_pend_rd(ctl_pend_rd), .host_rd(host_rd), .host_rdata(host_rdata),
        .host_ctl_we(host_ctl_we), .host_ctl_din(host_ctl_din),
        .host_stat_rd(host_stat_rd), .host_lsi_en(host_lsi_en),
        .host_err(host_err), .host_ovr(host_ovr), .host_rx_int(host_rx_int),
        .host_tmo_int(host_tmo_int), .host_ls_int(host_ls_int),
        .ctl_empty_int(ctl_empty_int), .fill_level(fill_level)
    );

    function automatic int lvl(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic mdl_reset();
        q.delete();
        m_sh = 0; m_err = 0; m_ovr = 0; m_dout = 0; m_trig = 0; m_rel = 4;
        m_rel_arm = 4; m_tcnt = 0; m_cei = 0; m_armed = 0; m_texp = 0;
    endtask

    task automatic mdl_step();
        int n0, n1, head, trg, lim;
        bit wok, rok;
        n0   = q.size();
        head = (n0 > 0) ? q[0] : 0;
        wok  = ctl_wr && (n0 < DEPTH);
        rok  = host_rd && (n0 > 0);
        m_err = host_stat_rd ? 0 : (m_err | (head >> 8));
        m_ovr = (ctl_wr && !wok) ? 1 : (host_stat_rd ? 0 : m_ovr);
        if (rok) begin
            m_dout = q[0] & 255;
            void'(q.pop_front());
        end
        if (wok) q.push_back((m_sh << 8) | int'(ctl_wdata));
        if (ctl_flag_we) m_sh = int'(ctl_flag_din);
        else if (wok) m_sh = 0;
        n1 = q.size();
        if (n1 != 0) m_cei = 0;
        else if (n0 != 0) m_cei = 1;
        else if (ctl_pend_rd) m_cei = 0;
        if (host_ctl_we) m_trig = int'(host_ctl_din[7:6]);
        trg = lvl(m_trig);
        if (n1 == 0 || n1 >= trg) begin
            m_armed = 0; m_texp = 0;
        end else if (wok || rok || !m_armed) begin
            m_armed = 1; m_texp = 0; m_tcnt = 0; m_rel_arm = m_rel;
        end else if (!m_texp && baud_tick) begin
            m_tcnt++;
            lim = (m_rel_arm < 1) ? 1 : m_rel_arm;
            if (m_tcnt >= lim) m_texp = 1;
        end
        if (ctl_tmo_we) m_rel = int'(ctl_tmo_din);
    endtask

    task automatic compare();
        int n, hf;
        n  = q.size();
        hf = (n > 0) ? (q[0] >> 8) : 0;
        chk(int'(fill_level) == n, "R2 fill", int'(fill_level), n);
        chk(int'(host_rdata) == m_dout, "R2 rdata", int'(host_rdata), m_dout);
        chk(int'(host_ovr) == m_ovr, "R3 ovr", int'(host_ovr), m_ovr);
        chk(int'(host_err) == m_err, "R7 err", int'(host_err), m_err);
        chk(int'(host_rx_int) == int'(n >= lvl(m_trig)), "R8 rx_int",
            int'(host_rx_int), int'(n >= lvl(m_trig)));
        chk(host_tmo_int == m_texp, "R9 tmo_int", int'(host_tmo_int), int'(m_texp));
        chk(int'(ctl_empty_int) == m_cei, "R11 empty_int", int'(ctl_empty_int), m_cei);
        chk(host_ls_int == (host_lsi_en && hf != 0), "R12 ls_int",
            int'(host_ls_int), int'(host_lsi_en && hf != 0));
    endtask

    task automatic clr();
        baud_tick = 0; ctl_flag_we = 0; ctl_wr = 0; ctl_tmo_we = 0;
        ctl_pend_rd = 0; host_rd = 0; host_ctl_we = 0; host_stat_rd = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        mdl_step();
        compare();
        clr();
    endtask

    task automatic wr(input int d);
        ctl_wr = 1; ctl_wdata = d[7:0]; step();
    endtask
    task automatic rd();
        host_rd = 1; step();
    endtask
    task automatic flag(input int f);
        ctl_flag_we = 1; ctl_flag_din = f[2:0]; step();
    endtask
    task automatic tick();
        baud_tick = 1; step();
    endtask
    task automatic setfcr(input int sel);
        host_ctl_we = 1; host_ctl_din = {sel[1:0], 6'b0}; step();
    endtask
    task automatic stat();
        host_stat_rd = 1; step();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lfsr;
        mdl_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(fill_level == 0 && host_rdata == 0, "R1 fill/rdata", int'(fill_level), 0);
        chk(host_err == 0 && !host_ovr && !host_rx_int && !host_tmo_int &&
            !host_ls_int && !ctl_empty_int, "R1 flags",
            int'({host_err, host_ovr, host_rx_int, host_tmo_int, host_ls_int, ctl_empty_int}), 0);

        // R2 ordering
        wr(8'h11); wr(8'h22); wr(8'h33);
        rd(); chk(host_rdata == 8'h11, "R2 first", int'(host_rdata), 8'h11);
        rd(); rd(); chk(host_rdata == 8'h33, "R2 third", int'(host_rdata), 8'h33);
        stat(); step();

        // R5 shadow flags copied then cleared
        flag(3'b001); wr(8'hA1); wr(8'hB2); step();
        rd();
        chk(host_err == 3'b001, "R7 sticky after read", int'(host_err), 1);
        stat(); step();
        chk(host_err == 3'b000, "R5 shadow cleared", int'(host_err), 0);
        rd(); stat(); step();

        // R6 flags visible only at the head
        wr(8'hC3); flag(3'b100); wr(8'hD4); step(); step();
        chk(host_err == 3'b000, "R6 not at head", int'(host_err), 0);
        rd(); step();
        chk(host_err == 3'b100, "R6 at head", int'(host_err), 4);
        // R12 line-status interrupt
        host_lsi_en = 1; step();
        chk(host_ls_int == 1'b1, "R12 enabled", int'(host_ls_int), 1);
        host_lsi_en = 0; step();
        chk(host_ls_int == 1'b0, "R12 disabled", int'(host_ls_int), 0);
        rd(); stat(); step();
        chk(ctl_empty_int == 1'b1, "R11 set on drain", int'(ctl_empty_int), 1);
        ctl_pend_rd = 1; step();
        chk(ctl_empty_int == 1'b0, "R11 pend clear", int'(ctl_empty_int), 0);

        // R4 empty read
        rd();
        chk(host_rdata == 8'hD4 && fill_level == 0, "R4 empty read", int'(host_rdata), 8'hD4);

        // R8 trigger 8, R3 overrun
        setfcr(2);
        for (int i = 0; i < DEPTH; i++) begin
            wr(8'h40 + i);
            if (i == 6) chk(!host_rx_int, "R8 below 8", int'(host_rx_int), 0);
            if (i == 7) chk(host_rx_int, "R8 at 8", int'(host_rx_int), 1);
        end
        wr(8'hEE);
        chk(host_ovr && fill_level == DEPTH, "R3 overrun", int'(host_ovr), 1);
        for (int i = 0; i < DEPTH; i++) rd();
        chk(host_rdata == 8'h4F, "R3 dropped byte absent", int'(host_rdata), 8'h4F);
        stat(); step();

        // R9/R10 time-out with trigger 4 and reload 3
        setfcr(1);
        ctl_tmo_we = 1; ctl_tmo_din = 8'd3; step();
        wr(8'h51); tick(); tick(); step();
        chk(!host_tmo_int, "R9 before expiry", int'(host_tmo_int), 0);
        tick();
        chk(host_tmo_int, "R9 expired", int'(host_tmo_int), 1);
        wr(8'h52);
        chk(!host_tmo_int, "R10 restart by write", int'(host_tmo_int), 0);
        tick(); tick(); tick();
        chk(host_tmo_int, "R9 expired again", int'(host_tmo_int), 1);
        wr(8'h53); tick(); tick(); tick(); wr(8'h54);
        chk(!host_tmo_int && host_rx_int, "R10 trigger reached", int'(host_tmo_int), 0);
        repeat (4) rd();
        setfcr(0);

        // Pseudo-random mixed traffic
        lfsr = 32'hC0FFEE01;
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ctl_wr       = (lfsr[3:0] < 6);
            ctl_wdata    = lfsr[15:8];
            host_rd      = (lfsr[7:4] < 6);
            ctl_flag_we  = (lfsr[18:16] == 0);
            ctl_flag_din = lfsr[21:19];
            baud_tick    = lfsr[22] & lfsr[23];
            host_stat_rd = (lfsr[26:24] == 0);
            ctl_pend_rd  = (lfsr[29:27] == 0);
            host_ctl_we  = (lfsr[31:27] == 5'h1F);
            host_ctl_din = {lfsr[9:8], 6'b0};
            ctl_tmo_we   = (lfsr[31:26] == 6'h15);
            ctl_tmo_din  = {5'b0, lfsr[12:10]};
            if (lfsr[31:28] == 4'h3) host_lsi_en = ~host_lsi_en;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule